// File: doc/BRIEF.md
# Power Controller I2C Register Slave

This block is the register front end of a step-down power controller. It listens on a two-wire I2C bus as a target with a 7-bit address. It holds the controller's configuration bytes and drives them to the rest of the chip. It also builds a status byte in which two live indicators sit next to six sticky fault flags. SCL and SDA are oversampled on the system clock. Each line passes through a synchronizer and a stability filter, so pulses shorter than the filter window never reach the protocol logic.

A master writes one register per transfer: address with W, pointer byte, data byte. It reads either in combined form (pointer write, repeated start, address with R) or with a separate read transfer. The second form works because the pointer is kept from the earlier transfer. There is no pointer increment. Fault sources pulse the flag inputs. The flags stay set until software writes the self-clearing clear-fault bit, the enable pin drops, or reset is applied.

Top module: `buck_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {4'b0001, addr_pins_i}. Bit 0 is the direction (0 write, 1 read). On any other address SDA is never driven.
- R2: After reset the stored registers hold 01h=01h, 02h=20h, 03h=2Eh, 04h=0Fh and 06h=3Bh, and SDA is released.
- R3: A write transfer (address+W, pointer, data) updates exactly one register and its output port. A second data byte in the same transfer is not acknowledged and changes nothing.
- R4: A combined read (address+W, pointer, repeated start, address+R) returns the register at the pointer.
- R5: The pointer survives a stop. A later read transfer that sends no pointer returns the register addressed before.
- R6: Writes to 00h and to unmapped pointers are acknowledged and discarded. Reads of unmapped pointers return 00h.
- R7: Bits 5:3 of register 06h always read as 1, whatever was written.
- R8: Register 00h reads {pgood_i, dcm_i, flags}. Bits 7 and 6 follow their inputs live. Flag bit k (bits 5..0: did-not-start, brown-out, current-limit, over-temperature, over-voltage, under-voltage) sets when fault_set_i[k] is high for a clock and stays set after the input drops.
- R9: All flags clear when 1 is written to bit 1 of 01h, and that bit reads back 0. All flags also clear while en_pin_i is low.
- R10: sw_enable_o equals en_pin_i AND bit 0 of 01h. Clearing bit 0 disables switching and leaves the flags unchanged.
- R11: The slave releases SDA on a stop and after a master NACK. It asserts SDA only while the filtered SCL is low.
- R12: A pulse on SCL or SDA shorter than FILT_CYCLES system clocks has no effect on a transfer.
- R13: A start or stop seen in the middle of a byte aborts the byte. A new transfer that follows works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| addr_pins_i | input | 3 | Low three bits of the device address |
| en_pin_i | input | 1 | Enable pin; low disables switching and clears flags |
| pgood_i | input | 1 | Live power-good indicator |
| dcm_i | input | 1 | Live discontinuous-mode indicator |
| fault_set_i | input | 6 | Fault set pulses, bit order as status bits 5..0 |
| sw_enable_o | output | 1 | Switching enable to the controller |
| ctrl1_o | output | 8 | Register 01h contents |
| cfg2_o | output | 8 | Register 02h contents |
| cfg3_o | output | 8 | Register 03h contents |
| cfg4_o | output | 8 | Register 04h contents |
| cfg6_o | output | 8 | Register 06h contents |

## Verification
The assertions take for granted that the master changes SDA only while SCL is low, apart from start and stop conditions. They also take for granted that en_pin_i and fault_set_i are synchronous to clk_i, and that each SCL phase lasts longer than synchronizer plus filter latency. The stimulus drives every input on the falling system-clock edge. It holds each bus quarter-bit for ten clocks, against a filter window of three. Its only deliberately short events are two-clock glitches, which exercise the filter without breaking the protocol.

// File: rtl/buck_i2c_pkg.sv
package buck_i2c_pkg;
  localparam int unsigned NUM_RW    = 5;
  localparam int unsigned NUM_FLAGS = 6;
  localparam logic [7:0]  STATUS_ADDR = 8'h00;

  // index 0 is the control register 01h
  localparam logic [NUM_RW-1:0][7:0] RW_ADDR = {8'h06, 8'h04, 8'h03, 8'h02, 8'h01};
  localparam logic [NUM_RW-1:0][7:0] RW_RST  = {8'h3B, 8'h0F, 8'h2E, 8'h20, 8'h01};
  localparam logic [NUM_RW-1:0][7:0] RW_SET1 = {8'h38, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam logic [NUM_RW-1:0][7:0] RW_CLR0 = {8'h00, 8'h00, 8'h00, 8'h00, 8'h02};

  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_CFG2 = 1;
  localparam int unsigned IDX_CFG3 = 2;
  localparam int unsigned IDX_CFG4 = 3;
  localparam int unsigned IDX_CFG6 = 4;
  localparam int unsigned BIT_SWEN = 0;
  localparam int unsigned BIT_CLRF = 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_PTR, ST_PTR_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_MACK
  } i2c_st_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned FILT_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CNT_W = $clog2(FILT_CYCLES + 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != line_o) begin
        // accept only after FILT_CYCLES consecutive differing samples
        if (cnt_q == CNT_W'(FILT_CYCLES - 1)) begin
          line_o <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  assign scl_rise_o = scl_f_i & ~scl_q;
  assign scl_fall_o = ~scl_f_i & scl_q;
  assign start_o    = scl_f_i & scl_q & sda_q & ~sda_f_i;
  assign stop_o     = scl_f_i & scl_q & ~sda_q & sda_f_i;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import buck_i2c_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sda_i,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] ptr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  i2c_st_e    st_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q, tx_q;
  logic       rw_q, mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      ptr_o     <= '0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      sda_oe_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        st_q     <= ST_DEV;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (scl_rise_i) begin
        if (st_q inside {ST_DEV, ST_PTR, ST_WDAT}) begin
          sh_q  <= {sh_q[6:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end else if (st_q == ST_RDAT) begin
          cnt_q <= cnt_q + 4'd1;
        end else if (st_q == ST_MACK) begin
          mack_q <= ~sda_i;
        end
      end else if (scl_fall_i) begin
        unique case (st_q)
          ST_DEV: if (cnt_q == 4'd8) begin
            if (sh_q[7:1] == dev_addr_i) begin
              st_q     <= ST_DEV_ACK;
              rw_q     <= sh_q[0];
              sda_oe_o <= 1'b1;
            end else begin
              st_q <= ST_IDLE;
            end
          end
          ST_DEV_ACK: begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q     <= rd_data_i;
              sda_oe_o <= ~rd_data_i[7];
              st_q     <= ST_RDAT;
            end else begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_PTR;
            end
          end
          ST_PTR: if (cnt_q == 4'd8) begin
            ptr_o    <= sh_q;
            sda_oe_o <= 1'b1;
            st_q     <= ST_PTR_ACK;
          end
          ST_PTR_ACK: begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            st_q     <= ST_WDAT;
          end
          ST_WDAT: if (cnt_q == 4'd8) begin
            wr_en_o   <= 1'b1;
            wr_data_o <= sh_q;
            sda_oe_o  <= 1'b1;
            st_q      <= ST_WDAT_ACK;
          end
          ST_WDAT_ACK: begin
            // one register per transfer: later bytes are not acknowledged
            sda_oe_o <= 1'b0;
            st_q     <= ST_IDLE;
          end
          ST_RDAT: if (cnt_q == 4'd8) begin
            sda_oe_o <= 1'b0;
            st_q     <= ST_MACK;
          end else begin
            tx_q     <= {tx_q[6:0], 1'b0};
            sda_oe_o <= ~tx_q[6];
          end
          ST_MACK: if (mack_q) begin
            tx_q     <= rd_data_i;
            sda_oe_o <= ~rd_data_i[7];
            cnt_q    <= '0;
            st_q     <= ST_RDAT;
          end else begin
            st_q <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/buck_reg_bank.sv
module buck_reg_bank
  import buck_i2c_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [7:0]           ptr_i,
  input  logic [7:0]           wr_data_i,
  input  logic                 en_pin_i,
  input  logic                 pgood_i,
  input  logic                 dcm_i,
  input  logic [NUM_FLAGS-1:0] fault_set_i,
  output logic [7:0]           rd_data_o,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 clr_pulse_o,
  output logic [7:0]           reg_o [NUM_RW]
);
  for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RW_RST[g];
      else if (wr_en_i && ptr_i == RW_ADDR[g]) q <= (wr_data_i | RW_SET1[g]) & ~RW_CLR0[g];
    end
    assign reg_o[g] = q;
  end

  assign clr_pulse_o = wr_en_i && (ptr_i == RW_ADDR[IDX_CTRL]) && wr_data_i[BIT_CLRF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      flags_o <= '0;
    else if (!en_pin_i || clr_pulse_o) flags_o <= '0;
    else                              flags_o <= flags_o | fault_set_i;
  end

  always_comb begin
    rd_data_o = '0;
    if (ptr_i == STATUS_ADDR) rd_data_o = {pgood_i, dcm_i, flags_o};
    for (int i = 0; i < NUM_RW; i++) begin
      if (ptr_i == RW_ADDR[i]) rd_data_o = reg_o[i];
    end
  end
endmodule

// File: rtl/buck_i2c_slave.sv
module buck_i2c_slave
  import buck_i2c_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 3,
  parameter logic [3:0]  DEV_ADDR_HI = 4'b0001
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic [2:0]           addr_pins_i,
  input  logic                 en_pin_i,
  input  logic                 pgood_i,
  input  logic                 dcm_i,
  input  logic [NUM_FLAGS-1:0] fault_set_i,
  output logic                 sw_enable_o,
  output logic [7:0]           ctrl1_o,
  output logic [7:0]           cfg2_o,
  output logic [7:0]           cfg3_o,
  output logic [7:0]           cfg4_o,
  output logic [7:0]           cfg6_o
);
  logic [1:0] raw, filt;
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] ptr, wr_data, rd_data;
  logic       wr_en, clr_pulse;
  logic [NUM_FLAGS-1:0] flags;
  logic [7:0] regs [NUM_RW];

  assign raw = {sda_i, scl_i};
  for (genvar l = 0; l < 2; l++) begin : g_line
    i2c_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[l]),
      .line_o(filt[l])
    );
  end
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  i2c_bus_events u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_f_i   (scl_f),
    .sda_f_i   (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_slave_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .sda_i     (sda_f),
    .dev_addr_i({DEV_ADDR_HI, addr_pins_i}),
    .rd_data_i (rd_data),
    .ptr_o     (ptr),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .sda_oe_o  (sda_oe_o)
  );

  buck_reg_bank u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .ptr_i      (ptr),
    .wr_data_i  (wr_data),
    .en_pin_i   (en_pin_i),
    .pgood_i    (pgood_i),
    .dcm_i      (dcm_i),
    .fault_set_i(fault_set_i),
    .rd_data_o  (rd_data),
    .flags_o    (flags),
    .clr_pulse_o(clr_pulse),
    .reg_o      (regs)
  );

  assign ctrl1_o     = regs[IDX_CTRL];
  assign cfg2_o      = regs[IDX_CFG2];
  assign cfg3_o      = regs[IDX_CFG3];
  assign cfg4_o      = regs[IDX_CFG4];
  assign cfg6_o      = regs[IDX_CFG6];
  assign sw_enable_o = en_pin_i & regs[IDX_CTRL][BIT_SWEN];
endmodule

// File: rtl/buck_i2c_checker.sv
module buck_i2c_checker #(
  parameter int unsigned NUM_FLAGS = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sda_oe_i,
  input logic                 scl_f_i,
  input logic                 stop_i,
  input logic                 en_pin_i,
  input logic                 clr_i,
  input logic [NUM_FLAGS-1:0] fault_set_i,
  input logic [NUM_FLAGS-1:0] flags_i
);
  p_release_on_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  p_drive_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_f_i);

  p_en_low_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_pin_i |=> (flags_i == '0));

  p_flags_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_pin_i && !clr_i) |=> (($past(flags_i) & ~flags_i) == '0));

  p_flags_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_pin_i && !clr_i && (|fault_set_i)) |=> ((flags_i & $past(fault_set_i)) == $past(fault_set_i)));
endmodule

bind buck_i2c_slave buck_i2c_checker #(.NUM_FLAGS(buck_i2c_pkg::NUM_FLAGS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_i   (sda_oe_o),
  .scl_f_i    (scl_f),
  .stop_i     (stop_det),
  .en_pin_i   (en_pin_i),
  .clr_i      (clr_pulse),
  .fault_set_i(fault_set_i),
  .flags_i    (flags)
);

// File: tb/tb_buck_i2c_slave.sv
module tb_buck_i2c_slave;
  localparam int CLK_PERIOD = 20;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe;
  logic       sda_line;
  logic [2:0] pins = 3'b101;
  logic       en_pin = 1'b1, pgood = 1'b0, dcm = 1'b0;
  logic [5:0] fset = '0;
  logic       sw_en;
  logic [7:0] ctrl1, cfg2, cfg3, cfg4, cfg6;

  assign sda_line = sda_m & ~sda_oe;

  buck_i2c_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_pins_i(pins), .en_pin_i(en_pin), .pgood_i(pgood), .dcm_i(dcm),
    .fault_set_i(fset), .sw_enable_o(sw_en), .ctrl1_o(ctrl1), .cfg2_o(cfg2),
    .cfg3_o(cfg3), .cfg4_o(cfg4), .cfg6_o(cfg6)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] shadow [8];
  logic [5:0] flg = '0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {4'b0001, pins, rw};
  endfunction

  function automatic logic mapped(input logic [7:0] a);
    return (a == 8'h01 || a == 8'h02 || a == 8'h03 || a == 8'h04 || a == 8'h06);
  endfunction

  function automatic logic [7:0] wmask(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h01) return d & 8'hFD;
    if (a == 8'h06) return d | 8'h38;
    return d;
  endfunction

  function automatic logic [7:0] port_val(input logic [7:0] a);
    case (a)
      8'h01: return ctrl1;
      8'h02: return cfg2;
      8'h03: return cfg3;
      8'h04: return cfg4;
      default: return cfg6;
    endcase
  endfunction

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); d[i] = sda_line; q(); scl_m = 1'b0;
    end
    sda_m = ~mack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    sda_m = 1'b1;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    logic ack;
    bus_start();
    put_byte(dev(1'b0), ack); chk("R3 addr ack", {7'b0, ack}, 8'd1);
    put_byte(a, ack);         chk("R3 ptr ack", {7'b0, ack}, 8'd1);
    put_byte(d, ack);         chk("R3 data ack", {7'b0, ack}, 8'd1);
    bus_stop();
  endtask

  task automatic rd_comb(input logic [7:0] a, output logic [7:0] d);
    logic ack;
    bus_start();
    put_byte(dev(1'b0), ack); chk("R4 addr ack", {7'b0, ack}, 8'd1);
    put_byte(a, ack);         chk("R4 ptr ack", {7'b0, ack}, 8'd1);
    bus_start();
    put_byte(dev(1'b1), ack); chk("R4 read ack", {7'b0, ack}, 8'd1);
    get_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  logic [7:0] alist [8] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h9A};

  initial begin
    logic [7:0] rd, a, d;
    logic ack, ack2;
    shadow = '{8'h00, 8'h01, 8'h20, 8'h2E, 8'h0F, 8'h00, 8'h3B, 8'h00};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 reset state
    chk("R2 ctrl1", ctrl1, 8'h01);
    chk("R2 cfg2", cfg2, 8'h20);
    chk("R2 cfg3", cfg3, 8'h2E);
    chk("R2 cfg4", cfg4, 8'h0F);
    chk("R2 cfg6", cfg6, 8'h3B);
    chk("R2 sda", {7'b0, sda_oe}, 8'd0);
    chk("R10 sw_en reset", {7'b0, sw_en}, 8'd1);

    // R1 address sweep
    for (int ad = 0; ad < 128; ad++) begin
      bus_start();
      put_byte({ad[6:0], 1'b0}, ack);
      bus_stop();
      chk("R1 match", {7'b0, ack}, {7'b0, (ad[6:0] == {4'b0001, pins})});
    end
    for (int p = 0; p < 8; p += 3) begin
      pins = p[2:0];
      bus_start(); put_byte(dev(1'b1), ack); get_byte(1'b0, rd); bus_stop();
      chk("R1 pins", {7'b0, ack}, 8'd1);
    end
    pins = 3'b101;

    // R3/R4/R6/R7 write-read per pointer
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 2; j++) begin
        a = alist[i];
        d = (j == 0) ? 8'hA5 : 8'h5A;
        wr_reg(a, d);
        if (mapped(a)) shadow[a[2:0]] = wmask(a, d);
        rd_comb(a, rd);
        if (a == 8'h06) chk("R7 readback", rd, shadow[6]);
        else if (mapped(a)) chk("R4 readback", rd, shadow[a[2:0]]);
        else chk("R6 unmapped", rd, 8'h00);
        if (mapped(a)) chk("R3 port", port_val(a), shadow[a[2:0]]);
        if (a == 8'h01) chk("R10 sw_en", {7'b0, sw_en}, {7'b0, shadow[1][0]});
      end
    end
    wr_reg(8'h01, 8'h01); shadow[1] = 8'h01;

    // R3 no auto-increment
    bus_start();
    put_byte(dev(1'b0), ack); put_byte(8'h02, ack); put_byte(8'h11, ack); put_byte(8'h22, ack2);
    bus_stop();
    shadow[2] = 8'h11;
    chk("R3 second byte nack", {7'b0, ack2}, 8'd0);
    chk("R3 single write", cfg2, 8'h11);
    chk("R3 neighbour kept", cfg3, shadow[3]);

    // R5 pointer retained, R11 release after NACK
    bus_start(); put_byte(dev(1'b0), ack); put_byte(8'h04, ack); bus_stop();
    bus_start(); put_byte(dev(1'b1), ack); get_byte(1'b0, rd);
    chk("R11 release after nack", {7'b0, sda_oe}, 8'd0);
    bus_stop();
    chk("R5 stop-separated read", rd, shadow[4]);
    chk("R11 release after stop", {7'b0, sda_oe}, 8'd0);

    // R8 live bits
    for (int v = 0; v < 4; v++) begin
      pgood = v[1]; dcm = v[0];
      rd_comb(8'h00, rd);
      chk("R8 live bits", rd, {v[1:0], 6'b0});
    end

    // R8 sticky flags one by one
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); fset = 6'(1 << k);
      @(negedge clk); fset = '0;
      flg = flg | 6'(1 << k);
      rd_comb(8'h00, rd);
      chk("R8 sticky", rd, {pgood, dcm, flg});
    end

    // R6 write to status discarded
    wr_reg(8'h00, 8'h00);
    rd_comb(8'h00, rd);
    chk("R6 status write ignored", rd, {pgood, dcm, flg});

    // R10 switch-off keeps flags
    wr_reg(8'h01, 8'h00);
    chk("R10 sw off", {7'b0, sw_en}, 8'd0);
    rd_comb(8'h00, rd);
    chk("R10 flags kept", rd, {pgood, dcm, flg});

    // R9 clear-fault bit
    wr_reg(8'h01, 8'h03);
    flg = '0;
    rd_comb(8'h00, rd);
    chk("R9 clear by bit", rd, {pgood, dcm, flg});
    rd_comb(8'h01, rd);
    chk("R9 self-clear", rd, 8'h01);
    chk("R10 sw back on", {7'b0, sw_en}, 8'd1);

    // R9 enable pin low
    @(negedge clk); fset = 6'h21;
    @(negedge clk); fset = '0;
    rd_comb(8'h00, rd);
    chk("R8 set before pin", rd, {pgood, dcm, 6'h21});
    en_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 pin low", {7'b0, sw_en}, 8'd0);
    en_pin = 1'b1;
    rd_comb(8'h00, rd);
    chk("R9 clear by pin", rd, {pgood, dcm, 6'h00});

    // R12 glitches on both lines inside a data byte
    bus_start(); put_byte(dev(1'b0), ack); put_byte(8'h03, ack);
    d = 8'hC3;
    for (int i = 7; i >= 0; i--) begin
      sda_m = d[i]; q();
      if (i == 5) begin
        scl_m = 1'b1; repeat (2) @(negedge clk); scl_m = 1'b0; q();
      end
      scl_m = 1'b1; q();
      if (i == 2) begin
        sda_m = ~d[i]; repeat (2) @(negedge clk); sda_m = d[i];
      end
      q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0; q();
    bus_stop();
    shadow[3] = 8'hC3;
    chk("R12 glitch ack", {7'b0, ack}, 8'd1);
    chk("R12 glitch data", cfg3, 8'hC3);

    // R13 start mid-byte
    bus_start();
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    wr_reg(8'h04, 8'h5C); shadow[4] = 8'h5C;
    chk("R13 restart write", cfg4, 8'h5C);

    // R13 stop mid-byte
    bus_start();
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    bus_stop();
    rd_comb(8'h04, rd);
    chk("R13 after stop read", rd, 8'h5C);

    summary();
    $finish;
  end
endmodule